// File: doc/BRIEF.md
# Word-Packing Peripheral DMA Controller

This block moves data from a peripheral byte stream into host memory. It takes bytes through a valid/ready handshake, pairs them into 16-bit words, and issues one memory write request per word. Each write goes to a 32-bit address counter, which then steps forward by two. A 32-bit word counter falls by one on each write. When that counter reaches zero the transfer ends and flags an end-of-transfer event.

The host works the block through a 16-bit register port addressed by word offset. This port reaches the status byte, the control word, both counter halves and a DACK width word. It also carries command strobes (start, stop, acknowledge, flush), which fire on either a read or a write of their offset. If the byte source runs dry in the middle of a transfer, the block asks for the next block and sleeps for one sector interval, then resumes. The single interrupt line is high only while the enable bit and the pending bit are both set.

Top module: `dma_word_ctl`

## Requirements
- R1: Host port offsets are 0x40 (word count high half), 0x41 (word count low half), 0x42 (address high half) and 0x43 (address low half). A write to one half leaves the other half unchanged. The control word at 0x21 is read/write. A write to 0x47 sets `dack_width`.
- R2: A read of offset 0x20 returns the status byte in bits 7..0, where bit 5 is end-of-transfer, bit 4 is pending and bit 0 is FIFO-empty. After the read, status bits 3..0 are cleared; bits 5 and 4 keep their values.
- R3: Offsets 0x70 (start), 0x71 (stop), 0x72 (clear pending bit 4) and 0x74 (set FIFO-empty bit 0) act on either a read or a write access.
- R4: Each memory word carries the first byte received in bits 15..8 and the second byte in bits 7..0.
- R5: Each accepted memory write presents the current address counter. It then adds 2 to the address counter and subtracts 1 from the word counter.
- R6: When the word counter is zero at the start of a word, the transfer stops and status bits 4 and 5 are set.
- R7: `irq` is high exactly when control bit 4 (interrupt enable) and status bit 4 are both 1. The line follows control writes at once.
- R8: A start strobe waits SECTOR_CYC cycles before the first fetch. If the source reports empty before a word is complete, the block pulses `src_next_blk` for one cycle and discards any half-built word. It then resumes fetching SECTOR_CYC+1 cycles after the pulse.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_wdata` and both counters hold their values.
- R10: A stop strobe cancels a pending resume and any unaccepted memory write. No more words are written, and the counters keep their values.
- R11: Reads of offsets 0x48 and 0x49 return 0x0000. Reads of offsets 0x51 to 0x53 return 0x00FF.
- R12: After reset, the status byte, the control word and both counters are zero. `irq`, `mem_req` and `src_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 8 | Word offset of the access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data (combinational, valid while host_sel) |
| src_valid | input | 1 | Source byte available |
| src_byte | input | 8 | Source byte |
| src_empty | input | 1 | Source has run dry |
| src_ready | output | 1 | Block takes the byte this cycle |
| src_next_blk | output | 1 | One-cycle request for the next block |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Write address (address counter) |
| mem_wdata | output | 16 | Packed write word |
| mem_ack | input | 1 | Memory accepts the request |
| dack_width | output | 16 | Programmed DACK width |
| irq | output | 1 | Interrupt line |

## Verification
The bench starves the source when one byte of a word is in hand. A design that kept the orphan byte would write a word shifted by one byte. A design that skipped the wait would resume too early, and the bench measures the resume gap. The bench also holds `mem_ack` low with a request out. If the counters or the address moved during that stall, a word would be lost or land at the wrong address. Strobes are issued through reads as well as writes, so decoding them only on writes leaves the interrupt pending or fails to cancel a transfer. The bench reads the status byte twice after a flush; if the low bits are not cleared on read, or bits 5 and 4 are wiped, the second read shows it.

// File: rtl/dwc_pkg.sv
// Shared constants and types for the word-packing DMA controller.
// Assumes a 16-bit host port with 8-bit word offsets and 32-bit counters.
package dwc_pkg;
    localparam int REG_W  = 16;
    localparam int CNT_W  = 32;
    localparam int HALF_W = CNT_W / 2;

    localparam logic [7:0] OFF_STAT  = 8'h20;
    localparam logic [7:0] OFF_CTRL  = 8'h21;
    localparam logic [7:0] OFF_CNT_H = 8'h40;
    localparam logic [7:0] OFF_CNT_L = 8'h41;
    localparam logic [7:0] OFF_ADR_H = 8'h42;
    localparam logic [7:0] OFF_ADR_L = 8'h43;
    localparam logic [7:0] OFF_DACK  = 8'h47;
    localparam logic [7:0] OFF_EXP0  = 8'h48;
    localparam logic [7:0] OFF_EXP1  = 8'h49;
    localparam logic [7:0] OFF_XT_LO = 8'h51;
    localparam logic [7:0] OFF_XT_HI = 8'h53;
    localparam logic [7:0] OFF_GO    = 8'h70;
    localparam logic [7:0] OFF_HALT  = 8'h71;
    localparam logic [7:0] OFF_ACK   = 8'h72;
    localparam logic [7:0] OFF_FLUSH = 8'h74;

    localparam int CT_IEN = 4;

    typedef enum logic [2:0] {
        E_IDLE,
        E_WAIT,
        E_HI,
        E_LO,
        E_PUT
    } eng_state_t;
endpackage

// File: rtl/dwc_sector_timer.sv
// Sector interval timer. A load starts a countdown of SECTOR_CYC cycles;
// expired is high in the last cycle of it. Cancel stops it silently.
// Assumes SECTOR_CYC >= 1.
module dwc_sector_timer #(
    parameter int SECTOR_CYC = 750000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic cancel,
    output logic expired
);
    localparam int TW = $clog2(SECTOR_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(SECTOR_CYC - 1);

    logic          running;
    logic [TW-1:0] cnt;

    assign expired = running && (cnt == '0);

    // Countdown: cancel wins, load restarts, otherwise count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (cancel) begin
            running <= 1'b0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= LAST;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dwc_regs.sv
// Host register port: counters, control, status, DACK width, strobe decode.
// Assumes one access per cycle; read data is combinational on host_off.
// Host writes to a counter take priority over the engine's step.
module dwc_regs
    import dwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [7:0]        host_off,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    input  logic              word_done,
    input  logic              xfer_done,
    output logic              go,
    output logic              halt,
    output logic [CNT_W-1:0]  wcnt,
    output logic [CNT_W-1:0]  acnt,
    output logic [REG_W-1:0]  dack_width,
    output logic              irq
);
    logic             wr_acc, rd_acc, ack_stb, flush_stb;
    logic [REG_W-1:0] ctrl;
    logic             st_eop, st_pend, st_empty;
    logic             cnt_hit, adr_hit;
    logic [7:0]       stat_byte;

    assign wr_acc    = host_sel && host_wr;
    assign rd_acc    = host_sel && !host_wr;
    assign go        = host_sel && (host_off == OFF_GO);
    assign halt      = host_sel && (host_off == OFF_HALT);
    assign ack_stb   = host_sel && (host_off == OFF_ACK);
    assign flush_stb = host_sel && (host_off == OFF_FLUSH);
    assign cnt_hit   = wr_acc && (host_off == OFF_CNT_H || host_off == OFF_CNT_L);
    assign adr_hit   = wr_acc && (host_off == OFF_ADR_H || host_off == OFF_ADR_L);
    assign stat_byte = {2'b00, st_eop, st_pend, 3'b000, st_empty};
    assign irq       = ctrl[CT_IEN] && st_pend;

    // Word counter: host half-writes, else decrement per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      wcnt <= '0;
        else if (wr_acc && host_off == OFF_CNT_H)        wcnt[CNT_W-1:HALF_W] <= host_wdata;
        else if (wr_acc && host_off == OFF_CNT_L)        wcnt[HALF_W-1:0]     <= host_wdata;
        else if (word_done)                              wcnt <= wcnt - 1'b1;
    end

    // Address counter: host half-writes, else advance by one word (2 bytes).
    always_ff @(posedge clk) begin
        if (!rst_n)                                      acnt <= '0;
        else if (wr_acc && host_off == OFF_ADR_H)        acnt[CNT_W-1:HALF_W] <= host_wdata;
        else if (wr_acc && host_off == OFF_ADR_L)        acnt[HALF_W-1:0]     <= host_wdata;
        else if (word_done)                              acnt <= acnt + CNT_W'(2);
    end

    // Control and DACK width words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            dack_width <= '0;
        end else if (wr_acc) begin
            if (host_off == OFF_CTRL) ctrl       <= host_wdata;
            if (host_off == OFF_DACK) dack_width <= host_wdata;
        end
    end

    // Status bits: completion sets pending and end-of-transfer (set beats clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_eop   <= 1'b0;
            st_pend  <= 1'b0;
            st_empty <= 1'b0;
        end else begin
            if (rd_acc && host_off == OFF_STAT) st_empty <= 1'b0;
            if (flush_stb)                      st_empty <= 1'b1;
            if (ack_stb)                        st_pend  <= 1'b0;
            if (xfer_done) begin
                st_pend <= 1'b1;
                st_eop  <= 1'b1;
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        host_rdata = '0;
        if (host_off == OFF_STAT)       host_rdata = {8'h00, stat_byte};
        else if (host_off == OFF_CTRL)  host_rdata = ctrl;
        else if (host_off == OFF_CNT_H) host_rdata = wcnt[CNT_W-1:HALF_W];
        else if (host_off == OFF_CNT_L) host_rdata = wcnt[HALF_W-1:0];
        else if (host_off == OFF_ADR_H) host_rdata = acnt[CNT_W-1:HALF_W];
        else if (host_off == OFF_ADR_L) host_rdata = acnt[HALF_W-1:0];
        else if (host_off >= OFF_XT_LO && host_off <= OFF_XT_HI) host_rdata = 16'h00FF;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !cnt_hit) |=> (wcnt == $past(wcnt) - 1'b1));              // R5
    AST_ADR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !adr_hit) |=> (acnt == $past(acnt) + CNT_W'(2)));         // R5
    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (stat_byte[5] && stat_byte[4]));                          // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && host_off == OFF_STAT) |=> (stat_byte[3:0] == 4'h0));         // R2
endmodule

// File: rtl/dwc_engine.sv
// Transfer engine: fetches byte pairs, packs them high byte first, issues
// one memory write per word and handles starvation and stop/start strobes.
// Assumes counters live in the register block; it only signals steps.
module dwc_engine
    import dwc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             halt,
    input  logic             cnt_zero,
    input  logic             tmr_expired,
    input  logic             src_valid,
    input  logic [7:0]       src_byte,
    input  logic             src_empty,
    output logic             src_ready,
    output logic             src_next_blk,
    output logic             tmr_load,
    output logic             mem_req,
    output logic [REG_W-1:0] mem_wdata,
    input  logic             mem_ack,
    output logic             word_done,
    output logic             xfer_done
);
    eng_state_t state;
    logic       quiet, fetching;

    assign quiet        = !go && !halt;
    assign fetching     = quiet && ((state == E_HI && !cnt_zero) || state == E_LO);
    assign src_ready    = fetching;
    assign src_next_blk = fetching && !src_valid && src_empty;
    assign tmr_load     = go || src_next_blk;
    assign mem_req      = quiet && (state == E_PUT);
    assign word_done    = mem_req && mem_ack;
    assign xfer_done    = quiet && (state == E_HI) && cnt_zero;

    // Sequencer and word assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= E_IDLE;
            mem_wdata <= '0;
        end else if (halt) begin
            state <= E_IDLE;
        end else if (go) begin
            state <= E_WAIT;
        end else begin
            case (state)
                E_WAIT: if (tmr_expired) state <= E_HI;
                E_HI: begin
                    if (cnt_zero) state <= E_IDLE;
                    else if (src_valid) begin
                        mem_wdata[15:8] <= src_byte;
                        state           <= E_LO;
                    end else if (src_empty) state <= E_WAIT;
                end
                E_LO: begin
                    if (src_valid) begin
                        mem_wdata[7:0] <= src_byte;
                        state          <= E_PUT;
                    end else if (src_empty) state <= E_WAIT;
                end
                E_PUT:   if (mem_ack) state <= E_HI;
                default: state <= E_IDLE;
            endcase
        end
    end

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_wdata));                          // R9
    AST_STARVE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (src_next_blk && !go && !halt) |=> (!src_ready && !mem_req));          // R8
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !go) |=> (!mem_req && !src_ready));                          // R10
endmodule

// File: rtl/dma_word_ctl.sv
// Top of the word-packing DMA controller: register port, engine and sector
// timer. Assumes SECTOR_CYC is the sector interval in clock cycles.
module dma_word_ctl
    import dwc_pkg::*;
#(
    parameter int SECTOR_CYC = 750000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic [7:0]  host_off,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        src_valid,
    input  logic [7:0]  src_byte,
    input  logic        src_empty,
    output logic        src_ready,
    output logic        src_next_blk,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ack,
    output logic [15:0] dack_width,
    output logic        irq
);
    logic             go, halt, word_done, xfer_done, tmr_load, tmr_expired;
    logic [CNT_W-1:0] wcnt, acnt;

    assign mem_addr = acnt;

    dwc_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_off(host_off),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .word_done(word_done), .xfer_done(xfer_done),
        .go(go), .halt(halt), .wcnt(wcnt), .acnt(acnt),
        .dack_width(dack_width), .irq(irq)
    );

    dwc_engine u_engine (
        .clk(clk), .rst_n(rst_n), .go(go), .halt(halt),
        .cnt_zero(wcnt == '0), .tmr_expired(tmr_expired),
        .src_valid(src_valid), .src_byte(src_byte), .src_empty(src_empty),
        .src_ready(src_ready), .src_next_blk(src_next_blk), .tmr_load(tmr_load),
        .mem_req(mem_req), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .word_done(word_done), .xfer_done(xfer_done)
    );

    dwc_sector_timer #(.SECTOR_CYC(SECTOR_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .cancel(halt),
        .expired(tmr_expired)
    );

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !(host_sel && host_wr)) |=> $stable(mem_addr)); // R9
endmodule

// File: tb/dma_word_ctl_bench.sv
// Directed bench for dma_word_ctl: one task per scenario.
module dma_word_ctl_bench;
    localparam int SECT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_off = 8'h00;
    logic [15:0] host_wdata = 16'h0000;
    logic [15:0] host_rdata;
    logic        src_valid, src_empty, src_ready, src_next_blk;
    logic [7:0]  src_byte;
    logic        mem_req, mem_ack;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, dack_width;
    logic        irq;
    logic        mem_hold = 1'b0;

    int n_chk = 0, n_err = 0;
    int src_idx = 0, src_avail = 0;
    int nlog = 0;
    logic [31:0] log_addr [64];
    logic [15:0] log_data [64];
    int cyc = 0, nb_count = 0, nb_cyc = 0, resume_cyc = 0;
    bit nb_pending = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(int k);
        return 8'(k * 37 + 5);
    endfunction

    assign src_valid = (src_idx < src_avail);
    assign src_empty = !src_valid;
    assign src_byte  = pat(src_idx);
    assign mem_ack   = !mem_hold;

    dma_word_ctl #(.SECTOR_CYC(SECT)) u_dma_word_ctl (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_off(host_off),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .src_valid(src_valid), .src_byte(src_byte), .src_empty(src_empty),
        .src_ready(src_ready), .src_next_blk(src_next_blk),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .dack_width(dack_width), .irq(irq)
    );

    // Peripheral and memory models plus starvation monitor.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (src_valid && src_ready) src_idx <= src_idx + 1;
        if (mem_req && mem_ack && nlog < 64) begin
            log_addr[nlog] <= mem_addr;
            log_data[nlog] <= mem_wdata;
            nlog <= nlog + 1;
        end
        if (src_next_blk) begin
            nb_count   <= nb_count + 1;
            nb_cyc     <= cyc;
            nb_pending <= 1'b1;
        end else if (src_ready && nb_pending) begin
            resume_cyc <= cyc;
            nb_pending <= 1'b0;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic hwrite(logic [7:0] off, logic [15:0] data);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_off = off; host_wdata = data;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic hread(logic [7:0] off, output logic [15:0] data);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_off = off;
        #1 data = host_rdata;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic wait_words(int target);
        for (int i = 0; i < 2000 && nlog < target; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R12 irq", irq, 0);
        chk("R12 mem_req", mem_req, 0);
        chk("R12 src_ready", src_ready, 0);
        hread(8'h20, v); chk("R12 status", v, 0);
        hread(8'h21, v); chk("R12 control", v, 0);
        hread(8'h41, v); chk("R12 count lo", v, 0);
        hread(8'h42, v); chk("R12 addr hi", v, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        hwrite(8'h40, 16'hABCD); hwrite(8'h41, 16'h1234);
        hread(8'h40, v); chk("R1 count hi", v, 16'hABCD);
        hread(8'h41, v); chk("R1 count lo", v, 16'h1234);
        hwrite(8'h40, 16'h5555);
        hread(8'h41, v); chk("R1 count lo kept", v, 16'h1234);
        hwrite(8'h43, 16'h0F0F); hwrite(8'h42, 16'h7777);
        hread(8'h43, v); chk("R1 addr lo kept", v, 16'h0F0F);
        hwrite(8'h47, 16'h0003);
        chk("R1 dack width", dack_width, 16'h0003);
        hwrite(8'h21, 16'h00F8);
        hread(8'h21, v); chk("R1 control rw", v, 16'h00F8);
        chk("R7 enable without pending", irq, 0);
        hwrite(8'h21, 16'h0000);
    endtask

    task automatic t_fixed();
        logic [15:0] v;
        hread(8'h48, v); chk("R11 exp 0x48", v, 16'h0000);
        hread(8'h49, v); chk("R11 exp 0x49", v, 16'h0000);
        hread(8'h51, v); chk("R11 xt 0x51", v, 16'h00FF);
        hread(8'h53, v); chk("R11 xt 0x53", v, 16'h00FF);
    endtask

    task automatic t_xfer();
        logic [15:0] v;
        int b, lb;
        hwrite(8'h40, 0); hwrite(8'h41, 4);
        hwrite(8'h42, 16'h0001); hwrite(8'h43, 0);
        hwrite(8'h21, 16'h0010);
        b = src_idx; lb = nlog; src_avail = src_idx + 8;
        hwrite(8'h70, 0);
        for (int i = 0; i < 1000 && !irq; i++) @(negedge clk);
        chk("R6 words written", nlog - lb, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R4 packed word", log_data[lb+i], {pat(b+2*i), pat(b+2*i+1)});
            chk("R5 word address", log_addr[lb+i], 32'h0001_0000 + 32'(2*i));
        end
        hread(8'h41, v); chk("R5 count at end", v, 0);
        hread(8'h43, v); chk("R5 addr lo at end", v, 16'h0008);
        chk("R7 irq on completion", irq, 1);
        hread(8'h20, v); chk("R6 status done", v, 16'h0030);
    endtask

    task automatic t_irq_status();
        logic [15:0] v;
        hwrite(8'h21, 16'h0000); chk("R7 irq masked", irq, 0);
        hwrite(8'h21, 16'h0010); chk("R7 irq unmasked", irq, 1);
        hread(8'h72, v);         chk("R3 ack by read", irq, 0);
        hread(8'h20, v);         chk("R3 pending cleared", v, 16'h0020);
        hwrite(8'h74, 0);
        hread(8'h20, v);         chk("R3 flush by write", v, 16'h0021);
        hread(8'h20, v);         chk("R2 low bits clear on read", v, 16'h0020);
        hread(8'h74, v);
        hread(8'h20, v);         chk("R3 flush by read", v, 16'h0021);
        hwrite(8'h21, 16'h0000);
    endtask

    task automatic t_starve();
        int b, lb, nb0;
        hwrite(8'h40, 0); hwrite(8'h41, 3);
        hwrite(8'h42, 0); hwrite(8'h43, 16'h0200);
        b = src_idx; lb = nlog; nb0 = nb_count; src_avail = src_idx + 3;
        hwrite(8'h70, 0);
        for (int i = 0; i < 500 && nb_count == nb0; i++) @(negedge clk);
        src_avail = src_idx + 10;
        chk("R8 starve request", nb_count, nb0 + 1);
        chk("R8 words before starve", nlog - lb, 1);
        wait_words(lb + 3);
        chk("R8 resume gap", resume_cyc - nb_cyc, SECT + 1);
        chk("R8 word0", log_data[lb], {pat(b), pat(b+1)});
        chk("R8 partial dropped", log_data[lb+1], {pat(b+3), pat(b+4)});
        chk("R8 word2", log_data[lb+2], {pat(b+5), pat(b+6)});
        chk("R5 addr after starve", log_addr[lb+2], 32'h0000_0204);
        chk("R8 single request", nb_count, nb0 + 1);
    endtask

    task automatic t_stall();
        logic [15:0] v;
        logic [15:0] d0;
        int lb;
        hwrite(8'h40, 0); hwrite(8'h41, 2);
        hwrite(8'h42, 0); hwrite(8'h43, 16'h0300);
        lb = nlog; src_avail = src_idx + 4; mem_hold = 1'b1;
        hwrite(8'h70, 0);
        for (int i = 0; i < 500 && !mem_req; i++) @(negedge clk);
        d0 = mem_wdata;
        repeat (5) @(negedge clk);
        chk("R9 addr held", mem_addr, 32'h0000_0300);
        chk("R9 data held", mem_wdata, d0);
        hread(8'h41, v); chk("R9 count held", v, 2);
        mem_hold = 1'b0;
        wait_words(lb + 2);
        chk("R9 words after stall", nlog - lb, 2);
        chk("R9 second addr", log_addr[lb+1], 32'h0000_0302);
    endtask

    task automatic t_stop();
        logic [15:0] v;
        int lb, si;
        hwrite(8'h40, 0); hwrite(8'h41, 5);
        hwrite(8'h42, 0); hwrite(8'h43, 16'h0400);
        lb = nlog; src_avail = src_idx + 20; si = src_idx;
        hwrite(8'h70, 0);
        repeat (5) @(negedge clk);
        hread(8'h71, v);
        repeat (3 * SECT) @(negedge clk);
        chk("R10 stop in wait: no words", nlog - lb, 0);
        chk("R10 stop in wait: no bytes", src_idx - si, 0);
        mem_hold = 1'b1;
        hwrite(8'h70, 0);
        for (int i = 0; i < 500 && !mem_req; i++) @(negedge clk);
        hwrite(8'h71, 0);
        chk("R10 request dropped", mem_req, 0);
        mem_hold = 1'b0;
        repeat (3 * SECT) @(negedge clk);
        chk("R10 stop in flight: no words", nlog - lb, 0);
        hread(8'h41, v); chk("R10 count kept", v, 5);
        hread(8'h43, v); chk("R10 addr kept", v, 16'h0400);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_fixed();
        t_xfer();
        t_irq_status();
        t_starve();
        t_stall();
        t_stop();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule